// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial front end of a small byte-wide non-volatile memory. It gathers the data bytes of a WRITE command into a page-sized latch, or the single status byte of a status-register write. When chip select is released, it decides whether to commit the command or throw it away. A committed command starts a self-timed program cycle. During that cycle the block pushes the stored bytes to the array write port, one per clock, and then holds busy for a fixed programming interval. The interval is counted in system clocks.

The front end reports four things as single-cycle strobes:
- the start of a command, with its kind and start address;
- every serial clock rising edge;
- every completed byte, delivered on the edge that captured its last bit;
- the chip-select rising edge.

A protection unit supplies a command-level permit and a two-bit region selector.

Bytes arrive on a valid/ready stream. `in_ready` is low for the whole program cycle. The front end must not offer bytes while `in_ready` is low. A byte offered in that state is not taken and leaves no trace.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, and neither `arr_we` nor `sr_we` is asserted.
- R2: The byte accepted k-th in a WRITE goes to address {page of `cmd_addr`, (low 4 bits of `cmd_addr` + k) mod 16}. The page bits never change, so offset Fh wraps to offset 0h of the same page.
- R3: When more than 16 bytes are sent, a later byte replaces an earlier one at the same offset. Each offset is programmed once, with the last value received for it.
- R4: Only offsets that received a byte in the current WRITE are written to the array. Offsets that received no byte get no `arr_we` and keep their old contents.
- R5: A WRITE commits only when `cs_rise` arrives after a byte has been accepted and before the next `sck_rise`. In every other case the command and its data are discarded: no `arr_we`, and no `busy`.
- R6: A status write (`cmd_is_sr`=1) commits only when `cs_rise` follows its first accepted byte with no `sck_rise` in between. On commit, `sr_we` pulses in the first busy cycle with `sr_bp` = bits [3:2] of that byte (bit 3 on `sr_bp[1]`).
- R7: If `wr_permit` is 0 when the commit is decided, nothing is programmed and `busy` stays 0.
- R8: `prot_sel` locks part of the array, and locked addresses are skipped at commit. The encodings are: 0 locks nothing; 1 locks the top quarter (60h–7Fh at 128 bytes); 2 locks the top half (40h–7Fh); 3 locks everything. A WRITE that is left with no unlocked byte does not raise `busy`.
- R9: `busy` rises in the cycle after the committing `cs_rise` and stays high for exactly 16 + PROG_CYCLES cycles. In busy cycle k (k = 0..15), offset k is written if it is marked, so the addresses ascend.
- R10: While `busy` is 1, `in_ready` is 0, and `cmd_start`, `cs_rise` and offered bytes have no effect. The cycle cannot be shortened, and no further writes result from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a WRITE or status-write opcode was decoded |
| cmd_is_sr | input | 1 | Kind of the starting command: 1 = status write, 0 = WRITE |
| cmd_addr | input | AW | Start address of a WRITE |
| sck_rise | input | 1 | Pulse for every serial clock rising edge |
| in_valid | input | 1 | Byte stream valid, asserted on the edge that completes a byte |
| in_ready | output | 1 | Byte stream ready; low during a program cycle |
| in_data | input | 8 | Byte stream data |
| cs_rise | input | 1 | Pulse: chip select was released |
| wr_permit | input | 1 | Command-level write permission from the protection unit |
| prot_sel | input | 2 | Locked region selector (see R8) |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status protection bits write strobe |
| sr_bp | output | 2 | New status protection bits |

## Verification
A commit decision is made on the `cs_rise` edge. `busy` and `in_ready` change one clock later. Offset k is written in the (k+1)-th clock after that edge, and `busy` falls 16 + PROG_CYCLES clocks after it rises. The bench drives every input just after a rising edge. Before that edge it steps a behavioural model on the same inputs, and it samples the outputs one nanosecond after the edge. The outputs are then compared with the model's prediction for that exact cycle. Across each scenario the bench also tallies writes, status strobes and busy lengths, and it checks a bench-side image of the array at the end.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PROG, SQ_WAIT} seq_state_t;
  typedef enum logic [1:0] {LOCK_NONE, LOCK_QTR, LOCK_HALF, LOCK_ALL} lock_sel_t;
endpackage

// File: rtl/pgw_latch.sv
module pgw_latch #(
  parameter int PAGE_BYTES = 16,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [PW-1:0]              off_in,
  input  logic                       wr,
  input  logic [7:0]                 din,
  output logic [PAGE_BYTES-1:0][7:0] data,
  output logic [PAGE_BYTES-1:0]      valid
);
  logic [PW-1:0] off;

  // offset counter only ever covers the low bits, so it wraps inside the page
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   off <= '0;
    else if (clr) off <= off_in;
    else if (wr)  off <= off + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= '0;
    end else if (clr) begin
      valid <= '0;
    end else if (wr) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (off == PW'(i)) begin
          data[i]  <= din;
          valid[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pgw_window.sv
module pgw_window (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic open_ev,
  input  logic edge_ev,
  output logic win
);
  // open after a completed byte, closed by the next serial edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win <= 1'b0;
    else if (clr)     win <= 1'b0;
    else if (open_ev) win <= 1'b1;
    else if (edge_ev) win <= 1'b0;
  end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1000000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAGE_BYTES-1:0] start_mask,
  input  logic                  start_sr,
  output logic                  busy,
  output logic                  slot_we,
  output logic [PW-1:0]         slot_idx,
  output logic                  sr_go
);
  seq_state_t            state;
  logic [PW-1:0]         idx;
  logic [CW-1:0]         cnt;
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      idx    <= '0;
      cnt    <= '0;
      mask_q <= '0;
      sr_q   <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_PROG;
          idx    <= '0;
          mask_q <= start_mask;
          sr_q   <= start_sr;
        end
        SQ_PROG: if (idx == PW'(PAGE_BYTES - 1)) begin
          state <= SQ_WAIT;
          cnt   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
        SQ_WAIT: if (cnt == CW'(PROG_CYCLES - 1)) state <= SQ_IDLE;
                 else cnt <= cnt + 1'b1;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state != SQ_IDLE);
  assign slot_we  = (state == SQ_PROG) && mask_q[idx];
  assign slot_idx = idx;
  assign sr_go    = (state == SQ_PROG) && (idx == '0) && sr_q;
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int AW          = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_is_sr,
  input  logic [AW-1:0] cmd_addr,
  input  logic          sck_rise,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          cs_rise,
  input  logic          wr_permit,
  input  logic [1:0]    prot_sel,
  output logic          busy,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          sr_we,
  output logic [1:0]    sr_bp
);
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int PGW   = AW - PW;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] QTR_BASE  = (AW+1)'(DEPTH - DEPTH / 4);
  localparam logic [AW:0] HALF_BASE = (AW+1)'(DEPTH / 2);

  logic                       active, is_sr, sr_got, win;
  logic [PGW-1:0]             page_q;
  logic [1:0]                 sr_byte;
  logic [PAGE_BYTES-1:0][7:0] lat_data;
  logic [PAGE_BYTES-1:0]      lat_valid, locked, wr_mask;
  logic                       start_ok, acc, commit, go;
  logic [PW-1:0]              slot_idx;
  lock_sel_t                  lsel;

  assign in_ready = !busy;
  assign start_ok = cmd_start && !busy && !cs_rise;
  assign acc      = in_valid && !busy && active && !cs_rise && !cmd_start;
  assign commit   = cs_rise && active && win && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_sr  <= 1'b0;
      page_q <= '0;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (start_ok) begin
      active <= 1'b1;
      is_sr  <= cmd_is_sr;
      page_q <= cmd_addr[AW-1:PW];
    end
  end

  // status write keeps only its first byte (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_got  <= 1'b0;
      sr_byte <= '0;
    end else if (start_ok) begin
      sr_got <= 1'b0;
    end else if (acc && is_sr && !sr_got) begin
      sr_got  <= 1'b1;
      sr_byte <= in_data[3:2];
    end
  end

  pgw_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .off_in(cmd_addr[PW-1:0]),
    .wr(acc && !is_sr), .din(in_data), .data(lat_data), .valid(lat_valid)
  );

  pgw_window u_win (
    .clk(clk), .rst_n(rst_n), .clr(start_ok || cs_rise),
    .open_ev(acc && (!is_sr || !sr_got)), .edge_ev(sck_rise), .win(win)
  );

  assign lsel = lock_sel_t'(prot_sel);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lock
    logic [AW:0] full;
    assign full = {1'b0, page_q, PW'(g)};
    always_comb begin
      unique case (lsel)
        LOCK_NONE: locked[g] = 1'b0;
        LOCK_QTR:  locked[g] = (full >= QTR_BASE);
        LOCK_HALF: locked[g] = (full >= HALF_BASE);
        default:   locked[g] = 1'b1;
      endcase
    end
  end

  assign wr_mask = lat_valid & ~locked;
  assign go      = commit && wr_permit && (is_sr || (|wr_mask));

  pgw_seq #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go),
    .start_mask(is_sr ? '0 : wr_mask), .start_sr(is_sr),
    .busy(busy), .slot_we(arr_we), .slot_idx(slot_idx), .sr_go(sr_we)
  );

  assign arr_addr  = {page_q, slot_idx};
  assign arr_wdata = lat_data[slot_idx];
  assign sr_bp     = sr_byte;
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int AW          = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1000000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          in_ready,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic          sr_we,
  input logic          cs_rise
);
  localparam int TOTAL = PAGE_BYTES + PROG_CYCLES;
  logic [31:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  assert_sr_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> busy);
  assert_no_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  assert_busy_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(TOTAL)));
  assert_addr_ascend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr > $past(arr_addr)));
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_ready(in_ready), .arr_we(arr_we),
  .arr_addr(arr_addr), .sr_we(sr_we), .cs_rise(cs_rise)
);

// File: tb/tb_pgw_ctrl.sv
`timescale 1ns/1ps
module tb_pgw_ctrl;
  localparam int AW = 7, PB = 16, PC = 20, TOTAL = PB + PC;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_is_sr = 0, sck_rise = 0, in_valid = 0, cs_rise = 0;
  logic wr_permit = 1;
  logic [1:0] prot_sel = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [7:0] in_data = 0;
  logic in_ready, busy, arr_we, sr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;
  logic [1:0] sr_bp;

  always #2 clk = ~clk;

  pgw_ctrl #(.AW(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_sr(cmd_is_sr),
    .cmd_addr(cmd_addr), .sck_rise(sck_rise), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cs_rise(cs_rise), .wr_permit(wr_permit), .prot_sel(prot_sel),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .sr_we(sr_we), .sr_bp(sr_bp)
  );

  int total = 0, bad = 0;
  int wcount = 0, srcount = 0, blen = 0;
  bit sawbusy = 0, prev_busy = 0;
  logic [1:0] last_bp = 0;
  logic [7:0] img [128];

  // behavioural reference model
  bit m_active, m_sr, m_win, m_srgot, m_run, m_srflag;
  int m_page, m_off, m_pos;
  logic [7:0] m_lat [PB];
  bit m_val [PB];
  bit m_mask [PB];
  logic [1:0] m_srbp, m_srv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit locked_at(input int a, input int sel);
    case (sel)
      0: return 0;
      1: return a >= 96;
      2: return a >= 64;
      default: return 1;
    endcase
  endfunction

  task automatic model_step();
    if (m_run) begin
      m_pos++;
      if (m_pos == TOTAL) m_run = 0;
    end else if (cs_rise) begin
      if (m_active && m_win) begin
        bit any = 0;
        for (int i = 0; i < PB; i++) begin
          m_mask[i] = !m_sr && m_val[i] && !locked_at(m_page * PB + i, prot_sel);
          any |= m_mask[i];
        end
        if (wr_permit && (m_sr || any)) begin
          m_run = 1; m_pos = 0; m_srflag = m_sr; m_srv = m_srbp;
        end
      end
      m_active = 0; m_win = 0;
    end else if (cmd_start) begin
      m_active = 1; m_sr = cmd_is_sr; m_page = cmd_addr / PB; m_off = cmd_addr % PB;
      for (int i = 0; i < PB; i++) m_val[i] = 0;
      m_win = 0; m_srgot = 0;
    end else if (m_active && in_valid) begin
      if (m_sr) begin
        if (!m_srgot) begin m_srbp = in_data[3:2]; m_srgot = 1; m_win = 1; end
        else if (sck_rise) m_win = 0;
      end else begin
        m_lat[m_off] = in_data; m_val[m_off] = 1; m_off = (m_off + 1) % PB; m_win = 1;
      end
    end else if (sck_rise) m_win = 0;
  endtask

  task automatic compare();
    bit e_we, e_sr;
    e_we = m_run && m_pos < PB && m_mask[m_pos];
    e_sr = m_run && m_pos == 0 && m_srflag;
    chk(busy == m_run, "R9 busy", busy, m_run);
    chk(in_ready == !m_run, "R10 in_ready", in_ready, !m_run);
    chk(arr_we == e_we, "R4 arr_we", arr_we, e_we);
    if (e_we) begin
      chk(arr_addr == AW'(m_page * PB + m_pos), "R2 arr_addr", arr_addr, m_page * PB + m_pos);
      chk(arr_wdata == m_lat[m_pos], "R3 arr_wdata", arr_wdata, m_lat[m_pos]);
    end
    chk(sr_we == e_sr, "R6 sr_we", sr_we, e_sr);
    if (e_sr) chk(sr_bp == m_srv, "R6 sr_bp", sr_bp, m_srv);
    if (arr_we) begin img[arr_addr] = arr_wdata; wcount++; end
    if (sr_we) begin srcount++; last_bp = sr_bp; end
    if (busy) begin sawbusy = 1; blen++; end
    else if (prev_busy) begin
      chk(blen == TOTAL, "R9 busy length", blen, TOTAL);
      blen = 0;
    end
    prev_busy = busy;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    compare();
    cmd_start = 0; sck_rise = 0; in_valid = 0; cs_rise = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic start_cmd(input bit sr, input int a);
    cmd_start = 1; cmd_is_sr = sr; cmd_addr = AW'(a); cyc();
  endtask

  task automatic send_byte(input logic [7:0] d);
    repeat (7) begin sck_rise = 1; cyc(); end
    sck_rise = 1; in_valid = 1; in_data = d; cyc();
  endtask

  task automatic end_cmd();
    cs_rise = 1; cyc();
  endtask

  task automatic clear_tally();
    wcount = 0; srcount = 0; sawbusy = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) img[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(arr_we == 0 && sr_we == 0, "R1 strobes", {arr_we, sr_we}, 0);
    idle(2);

    // R2/R4: two bytes at page 0
    clear_tally();
    start_cmd(0, 'h00); send_byte('hAA); send_byte('h55); end_cmd(); idle(TOTAL + 4);
    chk(wcount == 2, "R4 write count", wcount, 2);
    chk(img[0] == 'hAA, "R2 addr00", img[0], 'hAA);
    chk(img[1] == 'h55, "R2 addr01", img[1], 'h55);
    chk(img[2] == 'hFF, "R4 untouched 02", img[2], 'hFF);

    // R3: 18 bytes wrap and overwrite
    clear_tally();
    start_cmd(0, 'h00);
    for (int i = 0; i < 18; i++) send_byte(8'(i + 1));
    end_cmd(); idle(TOTAL + 4);
    chk(wcount == 16, "R3 write count", wcount, 16);
    chk(img[0] == 17, "R3 offset0 overwritten", img[0], 17);
    chk(img[1] == 18, "R3 offset1 overwritten", img[1], 18);
    chk(img[2] == 3, "R3 offset2", img[2], 3);

    // R2: wrap inside page from 1Eh
    clear_tally();
    start_cmd(0, 'h1E); send_byte('h11); send_byte('h22); send_byte('h33);
    end_cmd(); idle(TOTAL + 4);
    chk(img['h1E] == 'h11, "R2 1E", img['h1E], 'h11);
    chk(img['h1F] == 'h22, "R2 1F", img['h1F], 'h22);
    chk(img['h10] == 'h33, "R2 wrap 10", img['h10], 'h33);
    chk(img['h20] == 'hFF, "R2 next page untouched", img['h20], 'hFF);

    // R5: cancel after an extra edge, and with a partial byte
    clear_tally();
    start_cmd(0, 'h30); send_byte('h44); sck_rise = 1; cyc(); end_cmd(); idle(8);
    start_cmd(0, 'h30); repeat (3) begin sck_rise = 1; cyc(); end end_cmd(); idle(8);
    chk(wcount == 0, "R5 cancel writes", wcount, 0);
    chk(sawbusy == 0, "R5 cancel busy", sawbusy, 0);
    chk(img['h30] == 'hFF, "R5 cancel array", img['h30], 'hFF);

    // R7: no permit
    clear_tally(); wr_permit = 0;
    start_cmd(0, 'h40); send_byte('h5A); end_cmd(); idle(8);
    chk(wcount == 0 && sawbusy == 0, "R7 no permit", wcount, 0);
    wr_permit = 1;

    // R8: locked regions
    clear_tally(); prot_sel = 1;
    start_cmd(0, 'h60); send_byte('h01); send_byte('h02); end_cmd(); idle(8);
    chk(sawbusy == 0, "R8 quarter locked no busy", sawbusy, 0);
    start_cmd(0, 'h50); send_byte('h66); end_cmd(); idle(TOTAL + 4);
    chk(wcount == 1 && img['h50] == 'h66, "R8 below quarter written", img['h50], 'h66);
    clear_tally(); prot_sel = 2;
    start_cmd(0, 'h40); send_byte('h07); end_cmd(); idle(8);
    prot_sel = 3;
    start_cmd(0, 'h00); send_byte('h08); end_cmd(); idle(8);
    chk(wcount == 0 && sawbusy == 0, "R8 half/all locked", wcount, 0);
    prot_sel = 0;

    // R6: status write commit and cancels
    clear_tally();
    start_cmd(1, 0); send_byte('h0C); end_cmd(); idle(TOTAL + 4);
    chk(srcount == 1, "R6 status commit", srcount, 1);
    chk(last_bp == 2'b11, "R6 status bits", last_bp, 3);
    chk(wcount == 0, "R6 no array write", wcount, 0);
    clear_tally();
    start_cmd(1, 0); send_byte('h04); sck_rise = 1; cyc(); end_cmd(); idle(8);
    start_cmd(1, 0); send_byte('h04); send_byte('h08); end_cmd(); idle(8);
    chk(srcount == 0 && sawbusy == 0, "R6 status cancel", srcount, 0);

    // R10: inputs ignored while busy
    clear_tally();
    start_cmd(0, 'h70); send_byte('h77); end_cmd();
    chk(in_ready == 0, "R10 ready low", in_ready, 0);
    idle(2); start_cmd(0, 'h00); send_byte('h99); end_cmd();
    idle(TOTAL + 4);
    chk(wcount == 1, "R10 single write", wcount, 1);
    chk(img['h70] == 'h77, "R10 committed byte", img['h70], 'h77);
    chk(img[0] == 17, "R10 ignored byte", img[0], 17);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule